// File: doc/BRIEF.md
# Context-Partitioned Translation Buffer

This block is an address translation cache split into equal partitions, one per process context. Each partition is a small fully associative array of virtual-to-physical page mappings with permission bits. A switch request carries a context ID. The block does not flush on a switch. It makes a different partition the live one, so the mappings of up to four processes survive across switches. A process that is switched back in finds its earlier translations still present and takes no cold misses.

Only the live partition serves lookups and refills. The other partitions are held in a modelled power-gated state and report that state on one gate line each. A context ID that owns no partition takes over the partition that was switched to least recently, and that partition is wiped. Each switch costs one stall cycle on the lookup port. The wipe of a reclaimed partition is done in that cycle.

Top module: `ctx_tlb`

## Requirements
- R1: After reset, partition 0 is live and owned by context ID 0, `gate_en` reads 4'b1110 (bit p high means partition p is gated), `lkp_ready` is high and every lookup misses.
- R2: A lookup accepted at a clock edge (`lkp_valid` and `lkp_ready` high) gives `rsp_valid` high in the next cycle only, with `rsp_hit`, `rsp_ppn` and `rsp_perm` registered. On a miss `rsp_ppn` and `rsp_perm` read zero.
- R3: A refill writes its page mapping and 3-bit permission field into the live partition. A refill of a virtual page that is already present overwrites that entry in place.
- R4: Exactly one bit of `gate_en` is low at all times after reset, and it marks the live partition.
- R5: A switch request taken at an edge makes `lkp_ready` low for the following cycle. Lookups and refills offered in that cycle are dropped: no response comes out and no entry is written.
- R6: Switching to a context ID that already owns a partition makes that partition live and keeps all of its entries.
- R7: Entries written while one partition is live never hit while another partition is live.
- R8: A context ID that owns no partition is given the least recently switched-to partition, with every entry of that partition invalidated. From reset, the first three new IDs take partitions 3, 2 and 1 in that order.
- R9: Replacement within a partition fills invalid entries first (lowest free slot), then uses a binary-tree pseudo-LRU. Into an empty partition, after 16 refills of distinct pages with no lookups between them, the 17th refill evicts the first-filled page and the 18th evicts the ninth-filled page.
- R10: A gated partition receives no lookup, refill or wipe strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| lkp_ready | output | 1 | Low during the switch stall cycle |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page number on a hit, zero on a miss |
| rsp_perm | output | 3 | Permission bits on a hit, zero on a miss |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_perm | input | 3 | Refill permission bits |
| sw_valid | input | 1 | Context switch request |
| sw_ctx | input | CTX_W | Context ID being switched in |
| gate_en | output | NUM_PART | High for each gated partition |

## Verification
Lookups are tried against a present page, an absent page and a page rewritten in place, which separates the hit path from the miss zeroing and from the overwrite rule. Switch sequences use IDs that already own a partition and IDs that do not. Reading the same pages after each kind of switch separates retention, isolation and the wipe of a reclaimed partition, and the `gate_en` pattern shows which partition was chosen. A full partition is overfilled twice and every page is then probed, which shows the tree victim order apart from plain FIFO or first-slot reuse. Traffic offered in the stall cycle shows that it is dropped.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;
endpackage

// File: rtl/ctx_tlb_ctxmap.sv
module ctx_tlb_ctxmap #(
  parameter int NUM_PART = 4,
  parameter int CTX_W    = 8,
  localparam int PW      = $clog2(NUM_PART)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_valid,
  input  logic [CTX_W-1:0]    sw_ctx,
  output logic [PW-1:0]       active,
  output logic                stall,
  output logic                wipe,
  output logic [NUM_PART-1:0] gate
);
  logic [NUM_PART-1:0] own_vld_q;
  logic [CTX_W-1:0]    own_ctx_q [NUM_PART];
  logic [PW-1:0]       age_q     [NUM_PART];
  logic [NUM_PART-1:0] hit_vec;
  logic                hit_any;
  logic [PW-1:0]       hit_idx, old_idx, tgt;

  always_comb begin
    hit_idx = '0;
    old_idx = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      hit_vec[p] = own_vld_q[p] && (own_ctx_q[p] == sw_ctx);
      if (hit_vec[p]) hit_idx = PW'(p);
      if (age_q[p] == PW'(NUM_PART-1)) old_idx = PW'(p);
    end
    hit_any = |hit_vec;
    tgt     = hit_any ? hit_idx : old_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= '0;
      stall     <= 1'b0;
      wipe      <= 1'b0;
      gate      <= ~NUM_PART'(1);
      own_vld_q <= NUM_PART'(1);
      for (int p = 0; p < NUM_PART; p++) begin
        own_ctx_q[p] <= '0;
        age_q[p]     <= PW'(p);
      end
    end else if (sw_valid) begin
      active          <= tgt;
      stall           <= 1'b1;
      wipe            <= !hit_any;
      gate            <= ~(NUM_PART'(1) << tgt);
      own_vld_q[tgt]  <= 1'b1;
      own_ctx_q[tgt]  <= sw_ctx;
      for (int p = 0; p < NUM_PART; p++) begin
        if (PW'(p) == tgt) age_q[p] <= '0;
        else if (age_q[p] < age_q[tgt]) age_q[p] <= age_q[p] + 1'b1;
      end
    end else begin
      stall <= 1'b0;
      wipe  <= 1'b0;
    end
  end

  assert_wipe_in_stall_R8: assert property (@(posedge clk) disable iff (rst)
    wipe |-> stall);
  assert_stall_follows_switch_R5: assert property (@(posedge clk) disable iff (rst)
    sw_valid |=> stall);
endmodule

// File: rtl/ctx_tlb_part.sv
module ctx_tlb_part
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             powered,
  input  logic             wipe,
  input  logic             lkp_en,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output perm_t            hit_perm,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  perm_t            fill_perm
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [ENTRIES-1:1] plru_q, plru_nxt;

  logic          lkp_hit, fill_hit, free_any, touch_en;
  logic [IW-1:0] lkp_idx, fill_idx, free_idx, vic_idx, wr_idx, touch_idx;

  always_comb begin
    lkp_hit  = 1'b0; lkp_idx  = '0;
    fill_hit = 1'b0; fill_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int e = ENTRIES-1; e >= 0; e--) begin
      if (vld_q[e] && vpn_q[e] == lkp_vpn)  begin lkp_hit  = 1'b1; lkp_idx  = IW'(e); end
      if (vld_q[e] && vpn_q[e] == fill_vpn) begin fill_hit = 1'b1; fill_idx = IW'(e); end
      if (!vld_q[e])                        begin free_any = 1'b1; free_idx = IW'(e); end
    end
  end

  // tree walk: each node bit names the child holding the victim (1 = right)
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < IW; l++) node = 2 * node + int'(plru_q[node]);
    vic_idx = IW'(node - ENTRIES);
  end

  assign wr_idx    = fill_hit ? fill_idx : (free_any ? free_idx : vic_idx);
  assign touch_en  = fill_en || (lkp_en && lkp_hit);
  assign touch_idx = fill_en ? wr_idx : lkp_idx;

  always_comb begin
    int node;
    plru_nxt = plru_q;
    node     = int'(touch_idx) + ENTRIES;
    for (int l = 0; l < IW; l++) begin
      plru_nxt[node / 2] = (node % 2 == 0);
      node = node / 2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      vld_q  <= '0;
      plru_q <= '0;
    end else begin
      if (fill_en)  vld_q[wr_idx] <= 1'b1;
      if (touch_en) plru_q <= plru_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[wr_idx]  <= fill_vpn;
      ppn_q[wr_idx]  <= fill_ppn;
      perm_q[wr_idx] <= fill_perm;
    end
  end

  assign hit      = lkp_hit;
  assign hit_ppn  = ppn_q[lkp_idx];
  assign hit_perm = perm_q[lkp_idx];

  assert_gated_untouched_R10: assert property (@(posedge clk) disable iff (rst)
    !powered |-> !(lkp_en || fill_en || wipe));
  assert_wiped_empty_R8: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (vld_q == '0));
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int NUM_PART = 4,
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int CTX_W    = 8,
  localparam int PW      = $clog2(NUM_PART)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lkp_valid,
  input  logic [VPN_W-1:0]    lkp_vpn,
  output logic                lkp_ready,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [PPN_W-1:0]    rsp_ppn,
  output logic [2:0]          rsp_perm,
  input  logic                fill_valid,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [2:0]          fill_perm,
  input  logic                sw_valid,
  input  logic [CTX_W-1:0]    sw_ctx,
  output logic [NUM_PART-1:0] gate_en
);
  logic [PW-1:0] active;
  logic          stall, wipe, lkp_acc, fill_acc;
  logic          part_hit  [NUM_PART];
  logic [PPN_W-1:0] part_ppn [NUM_PART];
  perm_t         part_perm [NUM_PART];

  ctx_tlb_ctxmap #(.NUM_PART(NUM_PART), .CTX_W(CTX_W)) u_map (
    .clk(clk), .rst(rst), .sw_valid(sw_valid), .sw_ctx(sw_ctx),
    .active(active), .stall(stall), .wipe(wipe), .gate(gate_en)
  );

  assign lkp_ready = !stall;
  assign lkp_acc   = lkp_valid && !stall;
  assign fill_acc  = fill_valid && !stall;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    logic sel;
    assign sel = (active == PW'(p));
    ctx_tlb_part #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_part (
      .clk(clk), .rst(rst), .powered(!gate_en[p]), .wipe(wipe && sel),
      .lkp_en(lkp_acc && sel), .lkp_vpn(lkp_vpn),
      .hit(part_hit[p]), .hit_ppn(part_ppn[p]), .hit_perm(part_perm[p]),
      .fill_en(fill_acc && sel), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(perm_t'(fill_perm))
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lkp_acc;
      if (lkp_acc) begin
        rsp_hit  <= part_hit[active];
        rsp_ppn  <= part_hit[active] ? part_ppn[active] : '0;
        rsp_perm <= part_hit[active] ? 3'(part_perm[active]) : 3'b000;
      end
    end
  end

  assert_one_awake_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(~gate_en) == 1);
  assert_stall_after_switch_R5: assert property (@(posedge clk) disable iff (rst)
    sw_valid |=> !lkp_ready);
  assert_ready_without_switch_R5: assert property (@(posedge clk) disable iff (rst)
    !sw_valid |=> lkp_ready);
  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lkp_ready) |=> rsp_valid);
  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !(lkp_valid && lkp_ready) |=> !rsp_valid);
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == 3'b000));
endmodule

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20, PPN_W = 20, CTX_W = 8, NP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic lkp_valid = 0, fill_valid = 0, sw_valid = 0;
  logic [VPN_W-1:0] lkp_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [2:0] fill_perm = '0;
  logic [CTX_W-1:0] sw_ctx = '0;
  logic lkp_ready, rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  logic [2:0] rsp_perm;
  logic [NP-1:0] gate_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_tlb u0 (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
    .lkp_ready(lkp_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .sw_valid(sw_valid), .sw_ctx(sw_ctx), .gate_en(gate_en)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [VPN_W-1:0] v, string req, bit exp_hit,
                        logic [PPN_W-1:0] exp_ppn, logic [2:0] exp_perm);
    @(negedge clk); lkp_valid = 1; lkp_vpn = v;
    @(negedge clk); lkp_valid = 0;
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " hit"}, rsp_hit, exp_hit);
    chk({req, " ppn"}, rsp_ppn, exp_hit ? exp_ppn : '0);
    chk({req, " perm"}, rsp_perm, exp_hit ? exp_perm : 3'b0);
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [2:0] pm);
    @(negedge clk); fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic switch_to(logic [CTX_W-1:0] c, logic [NP-1:0] exp_gate, string req);
    @(negedge clk); sw_valid = 1; sw_ctx = c;
    @(negedge clk); sw_valid = 0;
    chk("R5 ready low in stall", lkp_ready, 0);
    @(negedge clk);
    chk("R5 ready back", lkp_ready, 1);
    chk({req, " gate_en"}, gate_en, exp_gate);
  endtask

  task automatic t_reset;
    chk("R1 gate_en", gate_en, 4'b1110);
    chk("R1 ready", lkp_ready, 1);
    chk("R1 rsp_valid idle", rsp_valid, 0);
    lookup(20'h00123, "R1 empty", 0, 0, 0);
  endtask

  task automatic t_basic;
    fill(20'h00010, 20'h000AB, 3'd5);
    lookup(20'h00010, "R2 R3 hit", 1, 20'h000AB, 3'd5);
    lookup(20'h00011, "R2 miss", 0, 0, 0);
    fill(20'h00010, 20'h000CD, 3'd3);
    lookup(20'h00010, "R3 overwrite", 1, 20'h000CD, 3'd3);
  endtask

  task automatic t_stall;
    @(negedge clk); sw_valid = 1; sw_ctx = 8'd7;
    @(negedge clk); sw_valid = 0;
    chk("R5 ready low", lkp_ready, 0);
    lkp_valid = 1; lkp_vpn = 20'h00077;
    fill_valid = 1; fill_vpn = 20'h00077; fill_ppn = 20'h00999; fill_perm = 3'd7;
    @(negedge clk); lkp_valid = 0; fill_valid = 0;
    chk("R5 dropped lookup", rsp_valid, 0);
    chk("R5 ready back", lkp_ready, 1);
    chk("R8 R4 new ctx to partition 3", gate_en, 4'b0111);
    lookup(20'h00077, "R5 dropped fill", 0, 0, 0);
    lookup(20'h00010, "R7 isolation", 0, 0, 0);
    fill(20'h00020, 20'h00222, 3'd1);
    lookup(20'h00020, "R3 fill ctx7", 1, 20'h00222, 3'd1);
  endtask

  task automatic t_return;
    switch_to(8'd0, 4'b1110, "R6 back to ctx0");
    lookup(20'h00010, "R6 retained", 1, 20'h000CD, 3'd3);
    lookup(20'h00020, "R7 other ctx hidden", 0, 0, 0);
    switch_to(8'd7, 4'b0111, "R6 back to ctx7");
    lookup(20'h00020, "R6 retained ctx7", 1, 20'h00222, 3'd1);
  endtask

  task automatic t_evict;
    // LRS order now: p0 then p3 most recent; p1, p2 oldest
    switch_to(8'd8, 4'b1011, "R8 ctx8 partition 2");
    switch_to(8'd9, 4'b1101, "R8 ctx9 partition 1");
    switch_to(8'd10, 4'b1110, "R8 ctx10 reclaims partition 0");
    lookup(20'h00010, "R8 reclaimed wiped", 0, 0, 0);
    switch_to(8'd7, 4'b0111, "R6 ctx7 kept partition 3");
    lookup(20'h00020, "R6 ctx7 still valid", 1, 20'h00222, 3'd1);
    switch_to(8'd0, 4'b1011, "R8 ctx0 reclaims partition 2");
  endtask

  task automatic t_plru;
    for (int i = 0; i < 16; i++) fill(20'h00100 + i, 20'h01100 + i, 3'(i));
    fill(20'h00200, 20'h01200, 3'd6);
    fill(20'h00201, 20'h01201, 3'd2);
    lookup(20'h00100, "R9 first-filled evicted", 0, 0, 0);
    lookup(20'h00108, "R9 ninth-filled evicted", 0, 0, 0);
    lookup(20'h00101, "R9 survivor", 1, 20'h01101, 3'd1);
    lookup(20'h0010F, "R9 survivor", 1, 20'h0110F, 3'd7);
    lookup(20'h00200, "R9 new", 1, 20'h01200, 3'd6);
    lookup(20'h00201, "R9 new", 1, 20'h01201, 3'd2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_basic();
    t_stall();
    t_return();
    t_evict();
    t_plru();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule